// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A memory-mapped watchdog for a system controller. Software programs a 16-bit timeout count and a 16-bit prescale divisor, then sets the enable bit. While the enable bit is set, a prescaler divides the base clock. Each prescaler wrap takes one step off a down-counter. When the down-counter reaches zero, the block drives a reset-request pulse of fixed width for the system reset generator. It also sets a sticky reset-cause flag.

Software keeps the timer alive by writing the restart bit into the status register. A restart reloads the counter from the programmed count and starts the prescaler again from zero. Clearing the enable bit freezes the timer and never fires it.

The cause flag is cleared only by the power-on reset input. The ordinary reset input also arrives when the watchdog itself resets the system, so boot code can still read the flag afterwards. The register bus is a plain 32-bit bus with an address, a write strobe, write data and combinational read data.

Top module: `wdt_prescaled`

## Requirements
- R1: After `rst_ni`, the control, load and status registers read 0, and `rst_req_o` is low. After `por_ni`, `cause_o` is also low.
- R2: Control at offset 0x20 reads back the divisor in bits [31:16] and the enable in bit 7. All other bits read 0.
- R3: Load at offset 0x24 reads back its 16-bit count in bits [15:0]. Bits [31:16] read 0.
- R4: Status at offset 0x00 always reads 0. Bit 9 is write-only and produces no stored state.
- R5: Call the edge that writes enable from 0 to 1 the start edge. With load count L and divisor D, `rst_req_o` is first seen high L*max(D,1)+1 clock edges after the start edge. A divisor of 0 behaves as 1.
- R6: A status write with bit 9 set reloads the counter and the prescaler. The timeout then restarts from that edge with the same formula as R5. A status write with bit 9 clear has no effect on the timing.
- R7: While enable is 0, the counter holds its value and no reset request is produced. Enabling again restarts the timing from the start edge, using a full period.
- R8: A write to the load register does not change a countdown already in progress. The new count is used at the next restart or the next enable transition from 0 to 1.
- R9: The reset request stays high for exactly PULSE_LEN cycles. After it ends there is no further request until a restart or a new enable.
- R10: `cause_o` sets together with the reset request. It survives `rst_ni` and is cleared only by `por_ni`.
- R11: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock; one prescaler step per cycle |
| rst_ni | input | 1 | Active-low async reset of the timer and its registers |
| por_ni | input | 1 | Active-low async power-on reset; the only clear for the cause flag |
| addr_i | input | AW | Byte offset of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| rst_req_o | output | 1 | Reset request pulse, PULSE_LEN cycles wide |
| cause_o | output | 1 | Sticky flag: the last system reset came from the watchdog |

## Verification
The bench measures the expiry edge exactly. It uses zero and one-step load counts, a divisor of zero and random count/divisor pairs. An off-by-one in the prescaler or the counter shifts the measured edge, and a zero divisor wired directly would stall or run too fast.

It writes a new load value during a countdown. A design that reloads at once would fire early. It also disables mid-count and then re-enables: a leaky enable fires while the timer is off, and a missing restart on enable fires too soon.

After an expiry it waits well past the pulse. A counter that wraps instead of stopping would request a second reset. It also pulses the ordinary reset input separately from the power-on input. A cause flag tied to the wrong reset is cleared by the watchdog's own reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 16;
  localparam int DIV_W = 16;

  localparam int OFS_STAT = 'h00;
  localparam int OFS_CTRL = 'h20;
  localparam int OFS_LOAD = 'h24;

  localparam int BIT_EN      = 7;
  localparam int BIT_RESTART = 9;
  localparam int DIV_LSB     = 16;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             en_o,
  output logic [DIV_W-1:0] div_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             reload_o
);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_LOAD = AW'(OFS_LOAD);

  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] load_q;
  logic             wr_stat, wr_ctrl, wr_load;

  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_load = we_i && (addr_i == A_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      load_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[BIT_EN];
        div_q <= wdata_i[DIV_LSB +: DIV_W];
      end
      if (wr_load) load_q <= wdata_i[CNT_W-1:0];
    end
  end

  // Reload on a kick, or when enable goes from 0 to 1.
  assign reload_o = (wr_stat && wdata_i[BIT_RESTART]) ||
                    (wr_ctrl && wdata_i[BIT_EN] && !en_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[DIV_LSB +: DIV_W] = div_q;
      rdata_o[BIT_EN]           = en_q;
    end else if (addr_i == A_LOAD) begin
      rdata_o[CNT_W-1:0] = load_q;
    end
  end

  assign en_o       = en_q;
  assign div_o      = div_q;
  assign load_val_o = load_q;

  AST_STAT_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STAT) |-> (rdata_o == 32'd0)); // R4
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] div_eff;

  // A zero divisor behaves as 1.
  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  // Use >= so that a smaller divisor written mid-period still wraps.
  assign tick_o  = en_i && !clr_i && (pre_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (en_i)    pre_q <= tick_o ? '0 : pre_q + DIV_W'(1);
  end

  AST_PRE_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pre_q)); // R7
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             fire_o,
  output logic             req_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [PW-1:0]    pul_q;

  assign fire_o = en_i && !load_i && !fired_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      fired_q <= 1'b0;
    end else if (fire_o) begin
      fired_q <= 1'b1;
    end else if (en_i && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pul_q <= '0;
    else if (fire_o)         pul_q <= PW'(PULSE_LEN);
    else if (pul_q != '0)    pul_q <= pul_q - PW'(1);
  end

  assign req_o = (pul_q != '0);

  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(en_i)); // R7
  AST_CNT_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q)); // R7
  AST_CNT_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q))); // R8
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !load_i) |=> !fire_o); // R9
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
  input  logic clk_i,
  input  logic por_ni,
  input  logic set_i,
  output logic cause_o
);
  logic cause_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)     cause_q <= 1'b0;
    else if (set_i)  cause_q <= 1'b1;
  end

  assign cause_o = cause_q;

  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    cause_q |=> cause_q); // R10
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          rst_req_o,
  output logic          cause_o
);
  logic             en, reload, tick, fire;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] load_val;

  wdt_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .en_o(en), .div_o(div), .load_val_o(load_val), .reload_o(reload)
  );

  wdt_prescaler u_pre (
    .clk_i, .rst_ni, .en_i(en), .clr_i(reload), .div_i(div), .tick_o(tick)
  );

  wdt_downcnt #(.PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .load_i(reload), .load_val_i(load_val),
    .tick_i(tick), .fire_o(fire), .req_o(rst_req_o)
  );

  wdt_cause u_cause (
    .clk_i, .por_ni, .set_i(fire), .cause_o
  );

  AST_REQ_FLAGS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rst_req_o |-> cause_o); // R10
endmodule

// File: tb/wdt_prescaled_test.sv
module wdt_prescaled_test;
  localparam int PULSE_LEN = 16;
  localparam logic [7:0] A_STAT = 8'h00, A_CTRL = 8'h20, A_LOAD = 8'h24, A_BAD = 8'h10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rst_req_o, cause_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_prescaled #(.AW(8), .PULSE_LEN(PULSE_LEN)) uut (
    .clk_i(clk), .rst_ni, .por_ni, .addr_i, .we_i, .wdata_i,
    .rdata_o, .rst_req_o, .cause_o
  );

  function automatic int exp_edges(int l, int d);
    return l * ((d == 0) ? 1 : d) + 1;
  endfunction

  function automatic logic [31:0] ctrl_word(int d, bit en);
    return {d[15:0], 8'h00, en, 7'h00};
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Caller sits at a negedge; one write uses one rising edge.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr_i = a; #1;
    check(rdata_o == exp, tag, rdata_o, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_fire(int start, int exp, string tag);
    int k = start; bit seen = 0;
    while (!seen && k < exp + 40) begin
      @(negedge clk); k++;
      if (rst_req_o) seen = 1;
    end
    check(seen && k == exp, tag, k, exp);
  endtask

  task automatic expect_width(string tag);
    int w = 1;
    while (rst_req_o && w < PULSE_LEN + 10) begin
      @(negedge clk);
      if (rst_req_o) w++;
    end
    check(w == PULSE_LEN, tag, w, PULSE_LEN);
  endtask

  task automatic arm(int l, int d);
    wr(A_CTRL, ctrl_word(d, 0));
    wr(A_LOAD, l);
    wr(A_CTRL, ctrl_word(d, 1));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: bench hung actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle(3);
    rst_ni = 1'b1; por_ni = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_LOAD, 0, "R1 load");
    rd(A_STAT, 0, "R1 stat");
    check(!rst_req_o && !cause_o, "R1 outputs", {rst_req_o, cause_o}, 0);

    // R2, R3 readback; R4 status
    wr(A_CTRL, 32'hABCD_FF7F);
    rd(A_CTRL, 32'hABCD_0000, "R2 ctrl mask");
    wr(A_LOAD, 32'h1234_5678);
    rd(A_LOAD, 32'h0000_5678, "R3 load mask");
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 0, "R4 stat reads zero");

    // R11 unmapped
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, 0, "R11 unmapped read");
    rd(A_CTRL, 32'hABCD_0000, "R11 ctrl untouched");
    rd(A_LOAD, 32'h0000_5678, "R11 load untouched");

    // R5 directed corners: zero load, zero divisor
    arm(0, 3);
    expect_fire(0, exp_edges(0, 3), "R5 load0");
    check(cause_o == 1'b1, "R10 cause set", cause_o, 1);
    expect_width("R9 pulse width");
    idle(40);
    check(!rst_req_o, "R9 no repeat", rst_req_o, 0);
    arm(7, 0);
    expect_fire(0, exp_edges(7, 0), "R5 div0");
    idle(PULSE_LEN + 2);
    arm(1, 1);
    expect_fire(0, exp_edges(1, 1), "R5 load1");
    idle(PULSE_LEN + 2);

    // R5 random pairs
    for (int i = 0; i < 12; i++) begin
      int l = $urandom_range(20, 0);
      int d = $urandom_range(6, 0);
      arm(l, d);
      expect_fire(0, exp_edges(l, d), $sformatf("R5 rand L=%0d D=%0d", l, d));
      idle(PULSE_LEN + 2);
    end

    // R6 restart, and status write without bit 9
    arm(10, 2);
    wr(A_STAT, 32'h0000_0100);
    idle(9);
    check(!rst_req_o, "R6 no early fire", rst_req_o, 0);
    wr(A_STAT, 32'h0000_0200);
    expect_fire(0, exp_edges(10, 2), "R6 restart timing");
    idle(PULSE_LEN + 2);
    arm(8, 1);
    wr(A_STAT, 32'h0000_0100);
    expect_fire(1, exp_edges(8, 1), "R6 bit9 clear ignored");
    idle(PULSE_LEN + 2);

    // R8 load written mid-count
    arm(5, 1);
    wr(A_LOAD, 50);
    expect_fire(1, exp_edges(5, 1), "R8 old load kept");
    idle(PULSE_LEN + 2);
    wr(A_STAT, 32'h0000_0200);
    expect_fire(0, exp_edges(50, 1), "R8 new load on restart");
    idle(PULSE_LEN + 2);

    // R7 disable holds, re-enable restarts fresh
    arm(10, 1);
    idle(3);
    wr(A_CTRL, ctrl_word(1, 0));
    idle(30);
    check(!rst_req_o, "R7 no fire while off", rst_req_o, 0);
    rd(A_CTRL, ctrl_word(1, 0), "R7 enable reads 0");
    wr(A_CTRL, ctrl_word(1, 1));
    expect_fire(0, exp_edges(10, 1), "R7 fresh period");
    idle(PULSE_LEN + 2);

    // R10 cause survives rst_ni, cleared by por_ni
    rst_ni = 1'b0; idle(2); rst_ni = 1'b1; idle(1);
    check(cause_o == 1'b1, "R10 survives rst", cause_o, 1);
    rd(A_CTRL, 0, "R1 ctrl after rst");
    check(!rst_req_o, "R1 req after rst", rst_req_o, 0);
    por_ni = 1'b0; rst_ni = 1'b0; idle(2); por_ni = 1'b1; rst_ni = 1'b1; idle(1);
    check(cause_o == 1'b0, "R10 cleared by por", cause_o, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule